// File: doc/BRIEF.md
# Low-Power Halt Sequencer with Oscillator Warm-up

This block sequences the low-power states of a processor subsystem. When the CPU issues a halt request, the sequencer reads a 2-bit mode code and enters one of three halt states. In deep stop every clock is gated, including the oscillator. In oscillator-only doze the oscillator keeps running, and the PLL keeps running if it is enabled, while the CPU and peripheral clocks stop. In I/O nap only the CPU clock stops, and the peripheral clocks keep running.

An interrupt line brings the block back to normal running from any halt state. A wake from doze or nap restores the CPU clock on the next cycle. A wake from deep stop has to wait for the oscillator to restart. In that case the block runs a warm-up count of a power-of-two number of oscillator cycles, chosen by a 2-bit code, before it re-enables the CPU and peripheral clocks. It then raises a one-cycle ready pulse.

The block runs on the oscillator-rate clock. All control pins are plain levels, and none has a handshake.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the block is running: `osc_en`, `cpu_clk_en` and `io_clk_en` are 1, `ready` is 0, and `pll_run` equals `pll_en`.
- R2: When the block is running and samples `halt_req` with `halt_mode` = 2'b01 (deep stop), `osc_en`, `pll_run`, `cpu_clk_en` and `io_clk_en` are all 0 from the next cycle until a wake.
- R3: With `halt_mode` = 2'b10 (oscillator-only doze), the next cycle gives `osc_en` = 1, `cpu_clk_en` = 0 and `io_clk_en` = 0. Whenever `osc_en` is 1, `pll_run` equals `pll_en`.
- R4: With `halt_mode` = 2'b11 (I/O nap), the next cycle gives `cpu_clk_en` = 0, `io_clk_en` = 1 and `osc_en` = 1.
- R5: A `wake_irq` sampled in doze or nap returns the block to running on the next cycle, with no warm-up and no `ready` pulse.
- R6: A `wake_irq` sampled in deep stop turns on `osc_en` on the next cycle. `cpu_clk_en` and `io_clk_en` stay 0 while the warm-up runs.
- R7: The warm-up lasts 2^WARM_EXP_SHORT cycles for `warm_sel` 2'b01 or 2'b00 (the reserved code falls back to the shortest count), 2^WARM_EXP_MID cycles for 2'b10, and 2^WARM_EXP_LONG cycles for 2'b11. After that the block is running again.
- R8: A halt request made while `halt_mode` = 2'b00 is ignored, and the CPU clock stays enabled.
- R9: `ready` is 1 for exactly one cycle: the first running cycle after a warm-up completes.
- R10: `halt_req` has no effect while the block is halted, and `wake_irq` has no effect while it is running. When both arrive in the same running cycle, the halt is taken.
- R11: `halt_mode` and `warm_sel` are captured when the halt is accepted. Changes made to them during the halt affect neither the halt state nor the warm-up length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request from the CPU, sampled while running |
| halt_mode | input | 2 | Halt state select: 01 deep stop, 10 doze, 11 nap, 00 reserved |
| warm_sel | input | 2 | Warm-up length select: 01/00 short, 10 mid, 11 long |
| pll_en | input | 1 | PLL enable setting |
| wake_irq | input | 1 | Interrupt wake request |
| osc_en | output | 1 | Oscillator enable |
| pll_run | output | 1 | PLL run enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| io_clk_en | output | 1 | Peripheral clock gate enable |
| ready | output | 1 | One-cycle pulse when a warm-up ends |

## Verification
The bench measures the exact length of each warm-up in cycles, for every select code including the reserved one. A counter that is off by one, or a decode of the wrong exponent, shows up as a wrong count. It checks the gating pattern of each halt state with the PLL both on and off. A design that mixed up doze and nap, or left the PLL running in deep stop, would show the wrong enables there.

The bench also sends a halt with the reserved mode code, a wake while running, a second halt while already halted, and a halt and a wake in the same cycle. A design that decoded the reserved code, or did not latch the halt, would stop the CPU or change state there. Finally, the bench changes the mode and warm-up selects in the middle of a deep stop. A design that did not capture them at entry would leave the halt early or warm up for the wrong length.

// File: rtl/standby_pkg.sv
package standby_pkg;

  // Halt mode codes as presented on halt_mode
  localparam logic [1:0] HM_RSVD  = 2'b00;
  localparam logic [1:0] HM_DEEP  = 2'b01;
  localparam logic [1:0] HM_DOZE  = 2'b10;
  localparam logic [1:0] HM_NAP   = 2'b11;

  // Warm-up select codes
  localparam logic [1:0] WS_RSVD  = 2'b00;
  localparam logic [1:0] WS_SHORT = 2'b01;
  localparam logic [1:0] WS_MID   = 2'b10;
  localparam logic [1:0] WS_LONG  = 2'b11;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_DEEP = 3'd1,
    ST_DOZE = 3'd2,
    ST_NAP  = 3'd3,
    ST_WARM = 3'd4
  } stby_state_t;

  typedef struct packed {
    logic osc;
    logic pll;
    logic cpu;
    logic io;
  } gate_set_t;

endpackage

// File: rtl/stby_warmup.sv
module stby_warmup #(
  parameter int EXP_SHORT = 8,
  parameter int EXP_MID   = 14,
  parameter int EXP_LONG  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       advance,
  input  logic [1:0] sel,
  output logic       done
);
  import standby_pkg::*;

  localparam int EXP_MAX = (EXP_LONG > EXP_MID) ?
                           ((EXP_LONG > EXP_SHORT) ? EXP_LONG : EXP_SHORT) :
                           ((EXP_MID > EXP_SHORT) ? EXP_MID : EXP_SHORT);
  localparam int CW = EXP_MAX + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;
  int            exp_sel;

  always_comb begin
    unique case (sel)
      WS_MID:  exp_sel = EXP_MID;
      WS_LONG: exp_sel = EXP_LONG;
      default: exp_sel = EXP_SHORT;
    endcase
    term = (CW'(1) << exp_sel) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= cnt + CW'(1);
  end

  assign done = advance && (cnt == term);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      halt_req,
  input  logic [1:0]                halt_mode,
  input  logic [1:0]                warm_sel_in,
  input  logic                      wake_irq,
  input  logic                      warm_done,
  output standby_pkg::stby_state_t  state,
  output logic [1:0]                warm_sel_q,
  output logic                      warm_clear,
  output logic                      warm_adv,
  output logic                      ready
);
  import standby_pkg::*;

  stby_state_t nxt;
  logic        accept;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (halt_req) begin
          unique case (halt_mode)
            HM_DEEP: begin nxt = ST_DEEP; accept = 1'b1; end
            HM_DOZE: begin nxt = ST_DOZE; accept = 1'b1; end
            HM_NAP:  begin nxt = ST_NAP;  accept = 1'b1; end
            default: nxt = ST_RUN;
          endcase
        end
      end
      ST_DEEP: if (wake_irq)  nxt = ST_WARM;
      ST_DOZE: if (wake_irq)  nxt = ST_RUN;
      ST_NAP:  if (wake_irq)  nxt = ST_RUN;
      ST_WARM: if (warm_done) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      warm_sel_q <= WS_SHORT;
      ready      <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) warm_sel_q <= warm_sel_in;
      ready <= (state == ST_WARM) && warm_done;
    end
  end

  assign warm_clear = (state == ST_DEEP);
  assign warm_adv   = (state == ST_WARM);

endmodule

// File: rtl/stby_gate.sv
module stby_gate (
  input  standby_pkg::stby_state_t state,
  input  logic                     pll_en,
  output standby_pkg::gate_set_t   gates
);
  import standby_pkg::*;

  always_comb begin
    gates = '{osc: 1'b1, pll: pll_en, cpu: 1'b0, io: 1'b0};
    unique case (state)
      ST_RUN:  begin gates.cpu = 1'b1; gates.io = 1'b1; end
      ST_NAP:  gates.io = 1'b1;
      ST_DOZE: ;
      ST_WARM: ;
      ST_DEEP: gates = '{osc: 1'b0, pll: 1'b0, cpu: 1'b0, io: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int WARM_EXP_SHORT = 8,
  parameter int WARM_EXP_MID   = 14,
  parameter int WARM_EXP_LONG  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic [1:0] halt_mode,
  input  logic [1:0] warm_sel,
  input  logic       pll_en,
  input  logic       wake_irq,
  output logic       osc_en,
  output logic       pll_run,
  output logic       cpu_clk_en,
  output logic       io_clk_en,
  output logic       ready
);
  import standby_pkg::*;

  stby_state_t state;
  gate_set_t   gates;
  logic [1:0]  warm_sel_q;
  logic        warm_clear, warm_adv, warm_done;

  stby_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .halt_mode   (halt_mode),
    .warm_sel_in (warm_sel),
    .wake_irq    (wake_irq),
    .warm_done   (warm_done),
    .state       (state),
    .warm_sel_q  (warm_sel_q),
    .warm_clear  (warm_clear),
    .warm_adv    (warm_adv),
    .ready       (ready)
  );

  stby_warmup #(
    .EXP_SHORT (WARM_EXP_SHORT),
    .EXP_MID   (WARM_EXP_MID),
    .EXP_LONG  (WARM_EXP_LONG)
  ) u_warm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (warm_clear),
    .advance (warm_adv),
    .sel     (warm_sel_q),
    .done    (warm_done)
  );

  stby_gate u_gate (
    .state  (state),
    .pll_en (pll_en),
    .gates  (gates)
  );

  assign osc_en     = gates.osc;
  assign pll_run    = gates.pll;
  assign cpu_clk_en = gates.cpu;
  assign io_clk_en  = gates.io;

endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic [1:0] halt_mode,
  input logic       pll_en,
  input logic       wake_irq,
  input logic       osc_en,
  input logic       pll_run,
  input logic       cpu_clk_en,
  input logic       io_clk_en,
  input logic       ready
);

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && halt_req && halt_mode == 2'b01 |=> !osc_en && !pll_run && !cpu_clk_en && !io_clk_en); // R2

  AST_PLL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> pll_run == pll_en); // R3

  AST_NAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && halt_req && halt_mode == 2'b11 |=> io_clk_en && !cpu_clk_en && osc_en); // R4

  AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    io_clk_en && !cpu_clk_en && wake_irq |=> cpu_clk_en && !ready); // R5

  AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en && wake_irq |=> osc_en && !cpu_clk_en && !io_clk_en); // R6

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && halt_req && halt_mode == 2'b00 |=> cpu_clk_en); // R8

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R9

  AST_READY_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cpu_clk_en && $past(osc_en && !cpu_clk_en && !io_clk_en)); // R9

endmodule

bind standby_ctrl standby_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_req   (halt_req),
  .halt_mode  (halt_mode),
  .pll_en     (pll_en),
  .wake_irq   (wake_irq),
  .osc_en     (osc_en),
  .pll_run    (pll_run),
  .cpu_clk_en (cpu_clk_en),
  .io_clk_en  (io_clk_en),
  .ready      (ready)
);

// File: tb/standby_ctrl_test.sv
module standby_ctrl_test;
  localparam int EA = 3;
  localparam int EB = 5;
  localparam int EC = 6;
  localparam int NV = 8;
  // fields: mode, warm_sel, pll_en, exp_io, exp_osc, exp_warm_len (0 = no warm-up)
  localparam int VEC [NV][6] = '{
    '{1, 1, 0, 0, 0, 8},
    '{1, 2, 1, 0, 0, 32},
    '{1, 3, 0, 0, 0, 64},
    '{1, 0, 1, 0, 0, 8},
    '{2, 1, 1, 0, 1, 0},
    '{2, 3, 0, 0, 1, 0},
    '{3, 2, 1, 1, 1, 0},
    '{3, 0, 0, 1, 1, 0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, halt_req, pll_en, wake_irq;
  logic [1:0] halt_mode, warm_sel;
  logic       osc_en, pll_run, cpu_clk_en, io_clk_en, ready;

  standby_ctrl #(.WARM_EXP_SHORT(EA), .WARM_EXP_MID(EB), .WARM_EXP_LONG(EC)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
    .warm_sel(warm_sel), .pll_en(pll_en), .wake_irq(wake_irq),
    .osc_en(osc_en), .pll_run(pll_run), .cpu_clk_en(cpu_clk_en),
    .io_clk_en(io_clk_en), .ready(ready)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic pulse_halt(input logic [1:0] m);
    @(negedge clk); halt_mode = m; halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic measure_warm(output int n);
    n = 0;
    while (!cpu_clk_en && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; halt_req = 1'b0; wake_irq = 1'b0;
    halt_mode = 2'b00; warm_sel = 2'b01; pll_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 osc_en", osc_en, 1);
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 io_clk_en", io_clk_en, 1);
    check("R1 ready", ready, 0);
    check("R1 pll_run", pll_run, 0);
    pll_en = 1'b1;
    @(negedge clk);
    check("R1 pll_run follows", pll_run, 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i][0] == 1) ? "R2" : (VEC[i][0] == 2) ? "R3" : "R4";
      @(negedge clk);
      warm_sel = VEC[i][1][1:0];
      pll_en   = VEC[i][2][0];
      pulse_halt(VEC[i][0][1:0]);
      check({tag, " cpu_clk_en"}, cpu_clk_en, 0);
      check({tag, " io_clk_en"}, io_clk_en, VEC[i][3]);
      check({tag, " osc_en"}, osc_en, VEC[i][4]);
      check({tag, " pll_run"}, pll_run, VEC[i][4] & VEC[i][2]);
      repeat (4) @(negedge clk);
      check({tag, " held"}, osc_en, VEC[i][4]);
      pulse_wake();
      if (VEC[i][5] != 0) begin
        check("R6 osc_en on wake", osc_en, 1);
        check("R6 cpu held off", cpu_clk_en, 0);
        check("R6 io held off", io_clk_en, 0);
        measure_warm(n);
        check("R7 warm length", n, VEC[i][5]);
        check("R9 ready pulse", ready, 1);
        check("R7 io back on", io_clk_en, 1);
        @(negedge clk);
        check("R9 ready single", ready, 0);
      end else begin
        check("R5 cpu back", cpu_clk_en, 1);
        check("R5 no ready", ready, 0);
      end
    end

    // R8: reserved mode code
    pulse_halt(2'b00);
    check("R8 cpu still on", cpu_clk_en, 1);
    check("R8 io still on", io_clk_en, 1);
    @(negedge clk);
    check("R8 cpu later", cpu_clk_en, 1);

    // R10: wake while running
    pulse_wake();
    check("R10 wake when running cpu", cpu_clk_en, 1);
    check("R10 wake when running ready", ready, 0);

    // R10: halt while in nap
    pulse_halt(2'b11);
    pulse_halt(2'b01);
    check("R10 second halt osc", osc_en, 1);
    check("R10 second halt io", io_clk_en, 1);
    pulse_wake();
    check("R10 nap exit", cpu_clk_en, 1);

    // R10: halt and wake together while running, doze wins
    @(negedge clk);
    halt_mode = 2'b10; halt_req = 1'b1; wake_irq = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; wake_irq = 1'b0;
    check("R10 simultaneous cpu", cpu_clk_en, 0);
    check("R10 simultaneous io", io_clk_en, 0);
    check("R3 doze osc", osc_en, 1);
    pulse_wake();
    check("R5 doze exit", cpu_clk_en, 1);

    // R11: selects captured at entry
    @(negedge clk); warm_sel = 2'b01;
    pulse_halt(2'b01);
    halt_mode = 2'b11; warm_sel = 2'b11;
    repeat (5) @(negedge clk);
    check("R11 mode latched osc", osc_en, 0);
    check("R11 mode latched io", io_clk_en, 0);
    pulse_wake();
    measure_warm(n);
    check("R11 warm latched", n, 8);
    check("R9 ready after latched warm", ready, 1);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule